// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the raw D+ and D- wires of a low-speed USB link and recovers the packet bytes. It runs on a clock that is eleven times the bit rate. A two-stage synchronizer on each wire comes before all other logic. When the line leaves idle, the block searches the opening preamble for its last J-to-K transition. It puts its first sample half a bit after that transition. It accepts the preamble only after it has seen K on two bit samples in a row.

From then on it decodes NRZI, removes the bits inserted by the stuffing rule, and shifts the data in least-significant bit first. Each completed byte is presented with a one-cycle write strobe. An edge seen between two samples moves the next sample point back to the middle of the bit, so a clock error of about one percent either way is absorbed.

An SE0 sample ends the packet and reports the byte count. A packet longer than the buffer is cut off with an overflow pulse. A preamble that never completes raises a sync-error pulse. PID, CRC, addressing and transmission belong to other blocks.

Top module: `ls_usb_rx`

## Requirements
- R1: After reset, all event outputs (`rx_we_o`, `pkt_end_o`, `ovf_o`, `sync_err_o`) are low and `pkt_len_o` is 0. The synchronizers reset to the idle J level.
- R2: Line levels are encoded as {D+,D-}. J is 01 and is the idle level, K is 10, and SE0 is 00. A K seen while idle starts the sync search. The receiver then waits for J, then for the K edge, and places a check sample half a bit (OSR/2 clocks) after that edge. Sync is accepted only if this sample and the sample one bit later both read K. If the second sample reads J, the search for the next K edge resumes. A preamble lengthened by extra K/J pairs is therefore still accepted.
- R3: The wait for J and the wait for the K edge are each limited to TMO_BITS*OSR clocks. On expiry, `sync_err_o` pulses for one cycle, no byte is written, and the receiver waits for J before searching again.
- R4: The data bit is 1 when the sampled level equals the level at the previous sample and 0 when it differs. The first data bit is compared with the final K of the sync.
- R5: Data bits fill a byte starting at bit 0. After each eighth kept bit, `rx_we_o` is high for exactly one cycle with the byte on `rx_data_o`.
- R6: After six consecutive 1 bits, the next bit is discarded and is not counted as data. The closing bit of the sync counts as the first of those 1s. The run may cross a byte boundary.
- R7: An SE0 at a sample point ends the packet. `pkt_end_o` pulses for one cycle while `pkt_len_o` equals the number of bytes written, and any partial byte is dropped.
- R8: When a byte completes and MAX_BYTES bytes have already been written in the packet, that byte is not written. `ovf_o` pulses instead, and the rest of the packet up to its SE0 is ignored without a `pkt_end_o`.
- R9: Packets are decoded without error when the bit period differs from OSR clocks by up to ±1.1%, stuffing included.
- R10: `pkt_len_o` holds its value after a packet and is cleared only when the next sync is accepted.
- R11: In any cycle at most one of `rx_we_o`, `pkt_end_o`, `ovf_o` and `sync_err_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ wire, asynchronous |
| dm_i | input | 1 | D- wire, asynchronous |
| rx_data_o | output | 8 | Received byte, valid with `rx_we_o` |
| rx_we_o | output | 1 | One-cycle write strobe per received byte |
| pkt_end_o | output | 1 | One-cycle pulse on a normal end of packet |
| pkt_len_o | output | $clog2(MAX_BYTES+1) | Bytes written in the current or last packet |
| ovf_o | output | 1 | One-cycle pulse when the packet exceeds MAX_BYTES |
| sync_err_o | output | 1 | One-cycle pulse when the sync search times out |

## Verification
In one sample cycle, a byte can complete while the stuffing run reaches six. The byte write and the arming of the stuffed-bit drop then fall together, and the stuffed bit must be dropped from the start of the next byte rather than shifted into it. Directed payloads such as 0xFC followed by 0x00, and runs of 0xFF, provoke this. Random packets at bit periods of 1088, 1100 and 1112 bench time units against a 100-unit clock add further cases. The bench judges the result by comparing every written byte and the final length with a model encoder that inserts the stuffed bits itself.

// File: rtl/ls_usb_rx.sv
module ls_usb_rx #(
  parameter int OSR       = 11,
  parameter int MAX_BYTES = 12,
  parameter int TMO_BITS  = 2
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dp_i,
  input  logic                           dm_i,
  output logic [7:0]                     rx_data_o,
  output logic                           rx_we_o,
  output logic                           pkt_end_o,
  output logic [$clog2(MAX_BYTES+1)-1:0] pkt_len_o,
  output logic                           ovf_o,
  output logic                           sync_err_o
);
  localparam int LW       = $clog2(MAX_BYTES+1);
  localparam int PW       = $clog2(OSR+1);
  localparam int HALF     = OSR/2;
  localparam int RECTR    = OSR-HALF+1;
  localparam int TMO_CLKS = TMO_BITS*OSR;
  localparam int TW       = $clog2(TMO_CLKS+1);

  typedef enum logic [2:0] {S_IDLE, S_WJ, S_WK, S_C1, S_C2, S_DATA, S_DRAIN, S_REST} st_t;

  st_t st;
  logic dp_m, dm_m, dp_s, dm_s, dp_p, dm_p;
  logic [PW-1:0] ph;
  logic [TW-1:0] tmo;
  logic [LW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    ones, bcnt;
  logic          last_k;

  wire line_k   = dp_s & ~dm_s;
  wire line_j   = ~dp_s & dm_s;
  wire line_se0 = ~dp_s & ~dm_s;
  wire edge_seen = (dp_s != dp_p) || (dm_s != dm_p);
  wire dbit     = (line_k == last_k);
  wire at_samp  = (ph == PW'(OSR));
  wire tmo_end  = (tmo == TW'(TMO_CLKS-1));

  assign pkt_len_o = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_m <= 1'b0; dm_m <= 1'b1;
      dp_s <= 1'b0; dm_s <= 1'b1;
      dp_p <= 1'b0; dm_p <= 1'b1;
    end else begin
      dp_m <= dp_i; dm_m <= dm_i;
      dp_s <= dp_m; dm_s <= dm_m;
      dp_p <= dp_s; dm_p <= dm_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ph         <= '0;
      tmo        <= '0;
      cnt        <= '0;
      sh         <= '0;
      ones       <= '0;
      bcnt       <= '0;
      last_k     <= 1'b0;
      rx_data_o  <= '0;
      rx_we_o    <= 1'b0;
      pkt_end_o  <= 1'b0;
      ovf_o      <= 1'b0;
      sync_err_o <= 1'b0;
    end else begin
      rx_we_o    <= 1'b0;
      pkt_end_o  <= 1'b0;
      ovf_o      <= 1'b0;
      sync_err_o <= 1'b0;
      case (st)
        S_IDLE:
          if (line_k) begin
            st  <= S_WJ;
            tmo <= '0;
          end
        S_WJ:
          if (line_j) begin
            st  <= S_WK;
            tmo <= '0;
          end else if (tmo_end) begin
            st         <= S_REST;
            sync_err_o <= 1'b1;
          end else tmo <= tmo + 1'b1;
        S_WK:
          if (line_k) begin
            st <= S_C1;
            ph <= PW'(1);
          end else if (tmo_end) begin
            st         <= S_REST;
            sync_err_o <= 1'b1;
          end else tmo <= tmo + 1'b1;
        S_C1:
          if (ph == PW'(HALF)) begin
            if (line_k) begin
              st <= S_C2;
              ph <= PW'(1);
            end else begin
              st  <= S_WK;
              tmo <= '0;
            end
          end else ph <= ph + 1'b1;
        S_C2:
          if (at_samp) begin
            if (line_k) begin
              st     <= S_DATA;
              ph     <= PW'(1);
              last_k <= 1'b1;
              ones   <= 3'd1;
              bcnt   <= '0;
              cnt    <= '0;
            end else begin
              st  <= S_WK;
              tmo <= '0;
            end
          end else ph <= ph + 1'b1;
        S_DATA:
          if (at_samp) begin
            ph <= PW'(1);
            if (line_se0) begin
              st        <= S_IDLE;
              pkt_end_o <= 1'b1;
            end else begin
              last_k <= line_k;
              if (ones == 3'd6) begin
                ones <= '0;
              end else begin
                ones <= dbit ? ones + 3'd1 : 3'd0;
                sh   <= {dbit, sh[7:1]};
                bcnt <= bcnt + 3'd1;
                if (bcnt == 3'd7) begin
                  if (cnt == LW'(MAX_BYTES)) begin
                    ovf_o <= 1'b1;
                    st    <= S_DRAIN;
                  end else begin
                    rx_we_o   <= 1'b1;
                    rx_data_o <= {dbit, sh[7:1]};
                    cnt       <= cnt + 1'b1;
                  end
                end
              end
            end
          end else if (edge_seen) ph <= PW'(RECTR);
          else ph <= ph + 1'b1;
        S_DRAIN:
          if (line_se0) st <= S_IDLE;
        S_REST:
          if (line_j) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_we_o, pkt_end_o, ovf_o, sync_err_o}) <= 1);

  assert_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_len_o <= LW'(MAX_BYTES));

  assert_ovf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> !rx_we_o);

  assert_stuff_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd6);

  assert_phase_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (ph >= PW'(1) && ph <= PW'(OSR)));

  assert_write_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we_o |-> $past(st == S_DATA));

  assert_end_leaves_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |-> st == S_IDLE);
endmodule

// File: tb/sim_ls_usb_rx.sv
module sim_ls_usb_rx;
  localparam int CLK_PERIOD = 100;
  localparam int NOM_BIT    = 1100;
  localparam logic [1:0] LJ = 2'b01;
  localparam logic [1:0] LK = 2'b10;
  localparam logic [1:0] LSE0 = 2'b00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0;
  logic dm = 1'b1;
  logic [7:0] rx_data;
  logic rx_we, pkt_end, ovf, sync_err;
  logic [3:0] pkt_len;

  ls_usb_rx u0 (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
    .rx_data_o(rx_data), .rx_we_o(rx_we), .pkt_end_o(pkt_end),
    .pkt_len_o(pkt_len), .ovf_o(ovf), .sync_err_o(sync_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [7:0] pkt [0:15];
  logic [1:0] lv [0:319];
  int nl;
  logic [7:0] got [0:31];
  int nwr, nend, novf, nserr, nmulti, last_len;

  always @(negedge clk) begin
    if (rx_we) begin
      if (nwr < 32) got[nwr] = rx_data;
      nwr++;
    end
    if (pkt_end) begin
      nend++;
      last_len = int'(pkt_len);
    end
    if (ovf) novf++;
    if (sync_err) nserr++;
    if (int'(rx_we) + int'(pkt_end) + int'(ovf) + int'(sync_err) > 1) nmulti++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nwr = 0; nend = 0; novf = 0; nserr = 0; nmulti = 0; last_len = -1;
  endtask

  function automatic logic [1:0] flip(input logic [1:0] l);
    return (l == LJ) ? LK : LJ;
  endfunction

  task automatic push(input logic [1:0] l);
    lv[nl] = l;
    nl++;
  endtask

  task automatic build(input int n, input int nzero);
    logic [1:0] cur;
    int ones;
    nl = 0;
    cur = LJ;
    for (int i = 0; i < 4; i++) push(LJ);
    for (int i = 0; i < nzero; i++) begin cur = flip(cur); push(cur); end
    push(cur);
    ones = 1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        if (pkt[i][b]) ones++;
        else begin cur = flip(cur); ones = 0; end
        push(cur);
        if (ones == 6) begin cur = flip(cur); push(cur); ones = 0; end
      end
    push(LSE0); push(LSE0);
    for (int i = 0; i < 4; i++) push(LJ);
  endtask

  task automatic drive(input int blen);
    longint t0, tg;
    t0 = longint'($time) + 23;
    for (int i = 0; i < nl; i++) begin
      tg = t0 + longint'(i) * blen;
      if (tg % (CLK_PERIOD/2) == 0) tg++;
      #(tg - longint'($time));
      {dp, dm} = lv[i];
    end
    #(blen);
    repeat (30) @(negedge clk);
  endtask

  task automatic run_pkt(input int n, input int blen, input int nzero);
    clear_mon();
    build(n, nzero);
    drive(blen);
    chk("R5 byte count", nwr, n);
    for (int i = 0; i < n; i++) chk("R4/R6 byte value", int'(got[i]), int'(pkt[i]));
    chk("R7 end pulses", nend, 1);
    chk("R7 reported length", last_len, n);
    chk("R10 length held", int'(pkt_len), n);
    chk("R3 no sync error", nserr, 0);
    chk("R8 no overflow", novf, 0);
    chk("R11 single event", nmulti, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    clear_mon();
    repeat (3) @(negedge clk);
    chk("R1 reset write", int'(rx_we), 0);
    chk("R1 reset end", int'(pkt_end), 0);
    chk("R1 reset ovf", int'(ovf), 0);
    chk("R1 reset sync err", int'(sync_err), 0);
    chk("R1 reset length", int'(pkt_len), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    pkt[0] = 8'hA5; pkt[1] = 8'h3C;
    run_pkt(2, NOM_BIT, 7);

    // R6: run of six ones ends on the last bit of a byte
    pkt[0] = 8'hFC; pkt[1] = 8'h00; pkt[2] = 8'hFF; pkt[3] = 8'hFF; pkt[4] = 8'h7E;
    run_pkt(5, NOM_BIT, 7);

    // R6: closing sync bit counts toward the run
    pkt[0] = 8'h1F; pkt[1] = 8'h80;
    run_pkt(2, NOM_BIT, 7);

    // R2: lengthened preamble
    pkt[0] = 8'h5A; pkt[1] = 8'hC3; pkt[2] = 8'h01;
    run_pkt(3, NOM_BIT, 11);

    // R9: slow and fast line at full length with stuffing
    for (int i = 0; i < 12; i++) pkt[i] = (i % 3 == 0) ? 8'hFF : 8'(8'h11 * i);
    run_pkt(12, 1112, 7);
    run_pkt(12, 1088, 7);

    // R3: K never followed by J
    clear_mon();
    {dp, dm} = LK;
    repeat (60) @(negedge clk);
    {dp, dm} = LJ;
    repeat (30) @(negedge clk);
    chk("R3 stuck K sync error", nserr, 1);
    chk("R3 stuck K no write", nwr, 0);

    // R2/R3: alternating preamble without closing KK
    clear_mon();
    nl = 0;
    for (int i = 0; i < 4; i++) push(LJ);
    for (int i = 0; i < 4; i++) begin push(LK); push(LJ); end
    for (int i = 0; i < 6; i++) push(LJ);
    drive(NOM_BIT);
    chk("R2 missing second K sync error", nserr, 1);
    chk("R2 missing second K no end", nend, 0);
    chk("R2 missing second K no write", nwr, 0);

    // R8: one byte beyond the limit
    clear_mon();
    for (int i = 0; i < 13; i++) pkt[i] = 8'(8'h21 + 8'd7 * i);
    build(13, 7);
    drive(NOM_BIT);
    chk("R8 bytes written", nwr, 12);
    for (int i = 0; i < 12; i++) chk("R8 kept byte", int'(got[i]), int'(pkt[i]));
    chk("R8 overflow pulse", novf, 1);
    chk("R8 no end pulse", nend, 0);
    chk("R8 length capped", int'(pkt_len), 12);

    // R10: shorter packet after a long one
    pkt[0] = 8'h99;
    run_pkt(1, NOM_BIT, 7);

    // R9: random packets at three bit periods
    for (int r = 0; r < 12; r++) begin
      int n, sel, bl;
      n = 1 + int'($urandom % 12);
      sel = int'($urandom % 3);
      bl = (sel == 0) ? 1088 : (sel == 1) ? 1100 : 1112;
      for (int i = 0; i < n; i++) pkt[i] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
      run_pkt(n, bl, 7);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule